// File: doc/BRIEF.md
# Sponge Message Padder

This block gathers a short message arriving as 128-bit transfers and turns it into one complete 1600-bit state block, ready to be fed to a Keccak-style permutation. A 2-bit digest select picks the output length. That choice sets the rate, which is the part of the state the message may fill, and the rest of the state (the capacity) is forced to zero. The message is padded inside the rate. A 0x01 byte follows the last message byte, and 0x80 goes into the final rate byte. When these two fall on the same byte they combine into 0x81.

The padded bytes are grouped into 64-bit lanes. Inside each lane the byte order is reversed, so the first byte of a group ends up in the least significant position. The lanes are then stacked from the top of the output vector downward. A message must leave at least one byte of the rate free. A message that is too long is dropped and reported with a one-cycle error pulse instead of a block. The finished block is offered on a valid/ready pair and is held until it is taken.

Top module: `sponge_padder`

## Requirements
- R1: The digest select is decoded as 0 → rate 1152 bits (144 bytes), 1 → 1088 (136 bytes), 2 → 832 (104 bytes) and 3 → 576 (72 bytes).
- R2: Within a transfer, byte k (k = 0..15) is `in_data[127-8k -: 8]`. Message byte p, counted from 0 across transfers, appears at `out_state[1536 - 64*(p/8) + 8*(p%8) +: 8]`.
- R3: For a message of L bytes, the byte at position L holds 0x01 in its low bit.
- R4: The byte at position R-1, where R is the rate in bytes, holds 0x80. When L equals R-1 that byte reads 0x81.
- R5: Every byte position above L and below R-1 is zero, and every position at R or above (the capacity) is zero.
- R6: Every transfer except the last carries 16 bytes. On the last transfer, `in_bytes` (0..16) gives how many bytes are valid, counted from the most significant byte. The remaining bytes of that transfer have no effect on the block.
- R7: A message with L > R-1 produces no block. Instead, `err` is high for exactly one cycle, in the cycle after the last transfer is accepted, and the next message is handled normally.
- R8: `out_valid` rises in the cycle after the last transfer of a fitting message is accepted. It stays high with `out_state` unchanged until `out_ready` is seen. While it is high, `in_ready` is low.
- R9: After reset, `out_valid` and `err` are low and `in_ready` is high.
- R10: The digest select is sampled on the first transfer of a message. Values presented on later transfers of the same message have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A message transfer is offered |
| in_ready | output | 1 | Transfer accepted when both are high |
| in_data | input | 128 | Message bytes, first byte in the top 8 bits |
| in_last | input | 1 | Marks the final transfer of a message |
| in_bytes | input | 5 | Valid byte count of the final transfer (0..16) |
| dsel | input | 2 | Digest select, sampled on the first transfer |
| out_valid | output | 1 | Finished state block available |
| out_ready | input | 1 | Consumer takes the block |
| out_state | output | 1600 | Padded, lane-mapped state block |
| err | output | 1 | One-cycle pulse for a message that does not fit |

## Verification
The assertions assume that `in_bytes` never exceeds 16 on a final transfer. The driver builds every final transfer from the message length, so it cannot present a larger count. The checks also assume that a message never exceeds one rate-sized block plus the overflow it reports. The longest stimulus message is 200 bytes, so the byte counter stays within its width. Unused bytes of a short final transfer are filled with non-zero filler, and the select is changed on later transfers, so that anything the block ought to ignore would show up in the compared state.

// File: rtl/spad_pkg.sv
package spad_pkg;

   typedef enum logic [1:0] {
      DG_224 = 2'd0,
      DG_256 = 2'd1,
      DG_384 = 2'd2,
      DG_512 = 2'd3
   } digest_e;

   localparam int unsigned SPONGE_BITS   = 1600;
   localparam int unsigned RATE_MAX_BITS = 1152;

   function automatic int unsigned rate_bits(input digest_e d);
      case (d)
         DG_224:  return 1152;
         DG_256:  return 1088;
         DG_384:  return 832;
         default: return 576;
      endcase
   endfunction

endpackage

// File: rtl/spad_rate_sel.sv
module spad_rate_sel
   import spad_pkg::*;
#(
   parameter int CW = 8
) (
   input  logic [1:0]    sel_i,
   output logic [CW-1:0] rate_bytes_o
);

   generate
      if ((RATE_MAX_BITS / 8) >= (1 << CW)) begin : g_chk_cw
         $error("spad_rate_sel: counter width too small for largest rate");
      end
      if ((rate_bits(DG_256) % 8) != 0 || (rate_bits(DG_384) % 8) != 0) begin : g_chk_byte
         $error("spad_rate_sel: rates must be whole bytes");
      end
   endgenerate

   always_comb begin
      rate_bytes_o = CW'(rate_bits(digest_e'(sel_i)) / 8);
   end

endmodule

// File: rtl/spad_collect.sv
module spad_collect #(
   parameter int BEAT_BITS = 128,
   parameter int BUF_BYTES = 144,
   parameter int CW        = 8,
   parameter int NW        = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   output logic                  in_ready,
   input  logic [BEAT_BITS-1:0]  in_data,
   input  logic                  in_last,
   input  logic [NW-1:0]         in_bytes,
   input  logic [CW-1:0]         rate_now,
   input  logic                  take_i,
   output logic                  hold_o,
   output logic                  err_o,
   output logic [CW-1:0]         len_o,
   output logic [CW-1:0]         rate_o,
   output logic [BUF_BYTES*8-1:0] buf_o
);

   localparam int BEAT_BYTES = BEAT_BITS / 8;
   localparam int SEGS       = (BUF_BYTES + BEAT_BYTES - 1) / BEAT_BYTES;
   localparam int SEG_SH     = $clog2(BEAT_BYTES);

   generate
      if ((1 << SEG_SH) != BEAT_BYTES) begin : g_chk_pow2
         $error("spad_collect: beat byte count must be a power of two");
      end
      if ((BUF_BYTES + BEAT_BYTES) >= (1 << CW)) begin : g_chk_cw
         $error("spad_collect: count width too small");
      end
   endgenerate

   logic [CW-1:0] cnt_q, rate_q, rate_use, n_eff, sum;
   logic          ovf_q, mid_q, hold_q, err_q, over, acc;
   logic [CW-1:0] seg_idx;
   logic [BEAT_BITS-1:0] seg_q [SEGS];

   assign acc      = in_valid && in_ready;
   assign in_ready = !hold_q;
   assign rate_use = mid_q ? rate_q : rate_now;
   assign seg_idx  = cnt_q >> SEG_SH;

   always_comb begin
      if (!in_last || CW'(in_bytes) > CW'(BEAT_BYTES)) n_eff = CW'(BEAT_BYTES);
      else                                              n_eff = CW'(in_bytes);
      sum  = cnt_q + n_eff;
      over = ovf_q || (sum >= rate_use);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         rate_q <= '0;
         ovf_q  <= 1'b0;
         mid_q  <= 1'b0;
         hold_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         err_q <= 1'b0;
         if (acc) begin
            rate_q <= rate_use;
            if (in_last) begin
               mid_q <= 1'b0;
               ovf_q <= 1'b0;
               if (over) begin
                  err_q <= 1'b1;
                  cnt_q <= '0;
               end else begin
                  cnt_q  <= sum;
                  hold_q <= 1'b1;
               end
            end else begin
               mid_q <= 1'b1;
               ovf_q <= over;
               if (!over) cnt_q <= sum;
            end
         end else if (hold_q && take_i) begin
            hold_q <= 1'b0;
            cnt_q  <= '0;
         end
      end
   end

   for (genvar s = 0; s < SEGS; s++) begin : g_seg
      always_ff @(posedge clk) begin
         if (acc && seg_idx == CW'(s)) seg_q[s] <= in_data;
      end
      for (genvar k = 0; k < BEAT_BYTES; k++) begin : g_byte
         if (s * BEAT_BYTES + k < BUF_BYTES) begin : g_map
            assign buf_o[(s*BEAT_BYTES+k)*8 +: 8] = seg_q[s][BEAT_BITS-1-8*k -: 8];
         end
      end
   end

   assign hold_o = hold_q;
   assign err_o  = err_q;
   assign len_o  = cnt_q;
   assign rate_o = rate_q;

   AST_LEN_FITS:    assert property (@(posedge clk) disable iff (!rst_n)
                       hold_q |-> (cnt_q < rate_q));                          // R7
   AST_ERR_PULSE:   assert property (@(posedge clk) disable iff (!rst_n)
                       err_q |=> !err_q);                                     // R7
   AST_ERR_NO_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
                       err_q |-> !hold_q);                                    // R7
   AST_SEL_LOCKED:  assert property (@(posedge clk) disable iff (!rst_n)
                       (acc && mid_q) |=> $stable(rate_q));                   // R10
   AST_BYTES_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
                       (in_valid && in_last) |-> (CW'(in_bytes) <= CW'(BEAT_BYTES))); // R6

endmodule

// File: rtl/spad_pad_map.sv
module spad_pad_map #(
   parameter int LANE_BITS = 64,
   parameter int LANES     = 25,
   parameter int BUF_BYTES = 144,
   parameter int CW        = 8
) (
   input  logic [BUF_BYTES*8-1:0]      buf_i,
   input  logic [CW-1:0]               len_i,
   input  logic [CW-1:0]               rate_i,
   output logic [LANES*LANE_BITS-1:0]  state_o
);

   localparam int LB          = LANE_BITS / 8;
   localparam int STATE_BYTES = LANES * LB;

   generate
      if (STATE_BYTES >= (1 << CW)) begin : g_chk_cw
         $error("spad_pad_map: byte index does not fit count width");
      end
   endgenerate

   logic [CW-1:0] last_pos;
   assign last_pos = rate_i - CW'(1);

   for (genvar p = 0; p < STATE_BYTES; p++) begin : g_byte
      logic [7:0] data_b, pad_b;
      if (p < BUF_BYTES) begin : g_msg
         assign data_b = (CW'(p) < len_i) ? buf_i[p*8 +: 8] : 8'h00;
      end else begin : g_cap
         assign data_b = 8'h00;
      end
      assign pad_b = ((CW'(p) == len_i)    ? 8'h01 : 8'h00)
                   | ((CW'(p) == last_pos) ? 8'h80 : 8'h00);
      assign state_o[(LANES-1-p/LB)*LANE_BITS + (p%LB)*8 +: 8] = data_b | pad_b;
   end

endmodule

// File: rtl/sponge_padder.sv
module sponge_padder
   import spad_pkg::*;
#(
   parameter int LANE_BITS = 64,
   parameter int LANES     = 25,
   parameter int BEAT_BITS = 128
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               in_valid,
   output logic                               in_ready,
   input  logic [BEAT_BITS-1:0]               in_data,
   input  logic                               in_last,
   input  logic [$clog2(BEAT_BITS/8+1)-1:0]   in_bytes,
   input  logic [1:0]                         dsel,
   output logic                               out_valid,
   input  logic                               out_ready,
   output logic [LANES*LANE_BITS-1:0]         out_state,
   output logic                               err
);

   localparam int BUF_BYTES = RATE_MAX_BITS / 8;
   localparam int NW        = $clog2(BEAT_BITS/8 + 1);
   localparam int CW        = $clog2(LANES*LANE_BITS/8 + 1);

   generate
      if (LANE_BITS % 8 != 0 || BEAT_BITS % 8 != 0) begin : g_chk_bytes
         $error("sponge_padder: lane and beat widths must be whole bytes");
      end
      if (LANES * LANE_BITS != SPONGE_BITS) begin : g_chk_state
         $error("sponge_padder: state must be 1600 bits for the rate table");
      end
   endgenerate

   logic [CW-1:0]          rate_now, len, rate;
   logic [BUF_BYTES*8-1:0] buf_flat;

   spad_rate_sel #(.CW(CW)) u_rate (
      .sel_i        (dsel),
      .rate_bytes_o (rate_now)
   );

   spad_collect #(
      .BEAT_BITS (BEAT_BITS),
      .BUF_BYTES (BUF_BYTES),
      .CW        (CW),
      .NW        (NW)
   ) u_coll (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_ready (in_ready),
      .in_data  (in_data),
      .in_last  (in_last),
      .in_bytes (in_bytes),
      .rate_now (rate_now),
      .take_i   (out_ready),
      .hold_o   (out_valid),
      .err_o    (err),
      .len_o    (len),
      .rate_o   (rate),
      .buf_o    (buf_flat)
   );

   spad_pad_map #(
      .LANE_BITS (LANE_BITS),
      .LANES     (LANES),
      .BUF_BYTES (BUF_BYTES),
      .CW        (CW)
   ) u_map (
      .buf_i   (buf_flat),
      .len_i   (len),
      .rate_i  (rate),
      .state_o (out_state)
   );

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
                       (out_valid && !out_ready) |=> (out_valid && $stable(out_state))); // R8
   AST_NO_TAKE_WHILE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
                       $rose(out_valid) |-> $past(in_valid && in_last));                 // R8

endmodule

// File: tb/sim_sponge_padder.sv
`timescale 1ns/1ps
module sim_sponge_padder;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
   logic [127:0]  in_data = '0;
   logic [4:0]    in_bytes = '0;
   logic [1:0]    dsel = '0;
   logic          in_ready, out_valid, err;
   logic [1599:0] out_state;

   int checks = 0, errors = 0, cyc = 0, sc = 0;
   bit done = 1'b0;

   typedef struct {
      bit            is_err;
      logic [1599:0] st;
      string         tag;
   } exp_t;
   exp_t q[$];

   always #2.5 clk = ~clk;

   sponge_padder u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_last(in_last), .in_bytes(in_bytes), .dsel(dsel),
      .out_valid(out_valid), .out_ready(out_ready), .out_state(out_state), .err(err)
   );

   function automatic int rate_of(input int d);
      case (d)
         0: return 144;
         1: return 136;
         2: return 104;
         default: return 72;
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [1599:0] act, input logic [1599:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   // Driver: builds a message, pushes the expected result, then sends the transfers
   task automatic send(input int L, input int d, input int d_later, input int seed, input string tag);
      logic [7:0]    msg [0:255];
      logic [1599:0] e;
      exp_t          it;
      int            R, nb;
      R = rate_of(d);
      for (int i = 0; i < 256; i++) msg[i] = 8'((i * 37 + seed * 11 + 5) & 255);
      e = '0;
      for (int p = 0; p < 200; p++) begin
         logic [7:0] b;
         b = (p < L) ? msg[p] : 8'h00;
         if (p == L)     b = b | 8'h01;
         if (p == R - 1) b = b | 8'h80;
         e[1536 - 64*(p/8) + 8*(p%8) +: 8] = b;
      end
      it.is_err = (L > R - 1);
      it.st     = e;
      it.tag    = tag;
      q.push_back(it);
      nb = (L == 0) ? 1 : (L + 15) / 16;
      @(negedge clk);
      for (int bt = 0; bt < nb; bt++) begin
         logic [127:0] dw;
         for (int k = 0; k < 16; k++) begin
            int idx;
            idx = 16*bt + k;
            dw[127-8*k -: 8] = (idx < L) ? msg[idx] : (8'hA5 ^ 8'(k));
         end
         in_data  = dw;
         in_valid = 1'b1;
         in_last  = (bt == nb - 1);
         in_bytes = (bt == nb - 1) ? 5'(L - 16*bt) : 5'd16;
         dsel     = (bt == 0) ? 2'(d) : 2'(d_later);
         while (!in_ready) @(negedge clk);
         @(negedge clk);
      end
      in_valid = 1'b0;
      in_last  = 1'b0;
   endtask

   // Monitor: pops expected items as results appear
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (err) begin
            if (q.size() == 0) chk(1'b0, "R7 unexpected err", 1600'd1, 1600'd0);
            else begin
               chk(q[0].is_err, {"R7 err for ", q[0].tag}, 1600'd1, 1600'(!q[0].is_err));
               void'(q.pop_front());
            end
         end
         if (out_valid) begin
            if (q.size() == 0) chk(1'b0, "R8 unexpected block", out_state, '0);
            else begin
               chk(!q[0].is_err && out_state === q[0].st, q[0].tag, out_state, q[0].st);
               chk(!in_ready, "R8 in_ready low while holding", 1600'(in_ready), 1600'd0);
            end
            out_ready = (sc % 3 == 2);
            if (out_ready && q.size() != 0) void'(q.pop_front());
         end else begin
            out_ready = 1'b0;
         end
         sc++;
      end
   end

   // Watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc >= 100000 && !done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", cyc, 0);
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!out_valid && !err && in_ready, "R9 reset state",
          1600'({out_valid, err, in_ready}), 1600'(3'b001));

      send(0,   0, 0, 1, "R1 R3 R4 empty msg sel0");
      send(0,   1, 1, 2, "R1 R3 R4 empty msg sel1");
      send(0,   2, 2, 3, "R1 R3 R4 empty msg sel2");
      send(0,   3, 3, 4, "R1 R3 R4 R5 empty msg sel3");
      send(1,   0, 0, 5, "R2 R6 one byte");
      send(16,  1, 1, 6, "R2 full single transfer");
      send(17,  2, 2, 7, "R2 R6 seventeen bytes");
      send(50,  3, 3, 8, "R2 R5 R6 fifty bytes");
      send(100, 0, 3, 9, "R10 select change ignored");
      send(71,  3, 3, 10, "R4 merged 0x81 sel3");
      send(103, 2, 2, 11, "R4 merged 0x81 sel2");
      send(135, 1, 1, 12, "R4 merged 0x81 sel1");
      send(143, 0, 0, 13, "R4 merged 0x81 sel0");
      send(72,  3, 3, 14, "R7 exactly rate overflows");
      send(40,  3, 3, 15, "R7 recovery after overflow");
      send(200, 0, 0, 16, "R7 long message");
      send(104, 2, 0, 17, "R7 R10 overflow under first select");
      send(33,  2, 2, 18, "R5 R6 after errors");

      while (q.size() != 0) @(negedge clk);
      repeat (5) @(negedge clk);
      chk(!out_valid && !err, "R8 idle at end", 1600'({out_valid, err}), 1600'd0);
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule